// File: doc/BRIEF.md
# Rewritable ID Key Programming Sequencer

This block drives the command side of a 1-Wire bus master to load a new 64-bit identity into a rewritable ID key. A host places the eight-byte identity on `id_in` and pulses `start`. The block checks and repairs the identity first. A family code other than 0x01 is replaced with 0x01. A check byte that does not match the CRC-8 of the other seven bytes is recomputed. An identity made only of zero bytes is refused before any bus traffic happens.

The block then runs a fixed conversation with the key. It sends a reset and a skip-ROM command, waits, and sends a second reset. It sends the write-identity command and pushes all 64 bits as single write slots, each bit inverted and each followed by a programming pause. After another pause it sends a third reset, a read-ROM command and eight byte reads. It compares the bytes it reads back with what it wrote. Every outcome is packed into one status byte. `done` stays high and the status stays frozen until the next accepted `start`.

The bus master is reached through a request/acknowledge handshake. `bus_req` stays high with a stable `bus_op`/`bus_wdata` until a one-cycle `bus_ack` arrives. On a reset acknowledge the master reports presence on `bus_presence`. On a read acknowledge it returns the byte on `bus_rdata`.

Top module: `ow_key_prog`

## Requirements
- R1: An identity whose 64 bits are all zero causes no bus request. One cycle after `start`, the block shows `done`=1, `busy`=0 and status 0xA0 (bit 7 error, bit 5 rejected).
- R2: If the family byte (`id_in[7:0]`) differs from 0x01, it is written as 0x01 and status bit 1 is set.
- R3: The check byte (`id_in[63:56]`) is compared with the CRC-8 of bytes 0..6. The CRC-8 uses polynomial x^8+x^5+x^4+1, takes bits LSB first, starts at zero, and is taken after the family repair. On mismatch the computed value is written instead and status bit 0 is set.
- R4: Bus operations are encoded as op 0 reset, op 1 write byte, op 2 write one slot (`bus_wdata[0]`) and op 3 read byte. They are issued in this order: reset, write 0xCC, reset, write 0xD5, 64 single slots, reset, write 0x33, 8 reads. Slot k carries the inverse of bit k of the repaired identity, with k=0 being the LSB of the family byte.
- R5: The gap between an acknowledge and the next request is 1 cycle, except in three places. It is 1+SKIP_DLY before the second reset. It is 1+BIT_DLY between two slots. It is 1+BIT_DLY+VERIFY_DLY before the third reset.
- R6: No presence on the first reset ends the sequence at once with status bit 7 plus the repair bits, and `done` is raised.
- R7: No presence on the second reset ends the sequence with status bits 7 and 2 plus the repair bits.
- R8: No presence on the third reset ends the sequence with status bits 7 and 3 plus the repair bits, after exactly 69 bus operations.
- R9: A read-back that differs from the written identity gives status bits 7 and 4 plus the repair bits. A matching read-back gives only the repair bits (0x00 to 0x03), with bits 7..2 zero.
- R10: `busy` and `done` are never both high. A `start` while busy is ignored. After completion, status and `done` hold until the next `start`, which clears `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin programming with `id_in` |
| id_in | input | 64 | New identity, byte 0 (family) in bits 7:0, check byte in bits 63:56 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result valid, held until next start |
| status | output | 8 | Result byte |
| bus_req | output | 1 | Bus master operation request |
| bus_op | output | 2 | Operation code |
| bus_wdata | output | 8 | Byte to write, or slot value in bit 0 |
| bus_ack | input | 1 | One-cycle completion from the bus master |
| bus_presence | input | 1 | Presence result, valid with ack of a reset |
| bus_rdata | input | 8 | Read byte, valid with ack of a read |

## Verification
The bench goes after four corner cases.

- **Repair ordering.** It feeds an identity whose check byte is right only once the family byte has been repaired. A design that computes the CRC over the raw family byte would wrongly set bit 0.
- **Presence failures.** It fails presence on each of the three resets in turn. It counts the operations issued, so a design that keeps going after a failure, or that tags the wrong reset, shows a different status or count.
- **Delay placement.** It measures the idle gaps. Two pauses merged into one, or a pause placed on the wrong side of a slot, change the measured cycle counts.
- **Slot polarity and busy handling.** It records the slot values into a key model and reads them back. A design that does not invert the slots fails the compare. A design that reloads its identity on a start that arrives while busy programs the wrong key.

// File: rtl/ow_prog_pkg.sv
package ow_prog_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WBYTE = 2'd1,
    OP_WSLOT = 2'd2,
    OP_RBYTE = 2'd3
  } ow_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST1, S_SKIP, S_DLY1, S_RST2, S_WCMD, S_WSLOT,
    S_WDLY, S_DLY2, S_RST3, S_RCMD, S_RBYTE, S_FIN
  } seq_state_e;

  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_WRID   = 8'hD5;
  localparam logic [7:0] CMD_READID = 8'h33;
  localparam logic [7:0] CRC_POLY_R = 8'h8C;

  localparam int ST_CRC_FIX = 0;
  localparam int ST_FAM_FIX = 1;
  localparam int ST_NP2     = 2;
  localparam int ST_NP3     = 3;
  localparam int ST_VERIFY  = 4;
  localparam int ST_ZERO    = 5;
  localparam int ST_ERR     = 7;

endpackage

// File: rtl/ow_id_fix.sv
module ow_id_fix #(
  parameter int         ID_BYTES    = 8,
  parameter logic [7:0] FAMILY_CODE = 8'h01
) (
  input  logic [ID_BYTES*8-1:0] id_raw,
  output logic [ID_BYTES*8-1:0] id_fixed,
  output logic                  fam_fixed,
  output logic                  crc_fixed,
  output logic                  all_zero
);
  import ow_prog_pkg::*;

  localparam int IDW  = ID_BYTES * 8;
  localparam int MSGW = IDW - 8;

  logic [MSGW-1:0] msg;
  logic [7:0]      chain [0:MSGW];

  assign msg = {id_raw[MSGW-1:8], FAMILY_CODE};
  assign chain[0] = 8'h00;

  for (genvar i = 0; i < MSGW; i++) begin : g_crc
    assign chain[i+1] = {1'b0, chain[i][7:1]} ^
                        ((chain[i][0] ^ msg[i]) ? CRC_POLY_R : 8'h00);
  end

  assign fam_fixed = (id_raw[7:0] != FAMILY_CODE);
  assign crc_fixed = (id_raw[IDW-1:MSGW] != chain[MSGW]);
  assign all_zero  = (id_raw == '0);
  assign id_fixed  = {chain[MSGW], msg};

endmodule

// File: rtl/ow_delay_timer.sv
module ow_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired = run && (cnt_q == limit - 1'b1);
  assign cnt_en  = run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (!run || expired) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: a running count never passes its limit
  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/ow_key_prog.sv
module ow_key_prog #(
  parameter int         SKIP_DLY    = 500,
  parameter int         BIT_DLY     = 500000,
  parameter int         VERIFY_DLY  = 500,
  parameter logic [7:0] FAMILY_CODE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] id_in,
  output logic        busy,
  output logic        done,
  output logic [7:0]  status,
  output logic        bus_req,
  output logic [1:0]  bus_op,
  output logic [7:0]  bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_presence,
  input  logic [7:0]  bus_rdata
);
  import ow_prog_pkg::*;

  localparam int ID_BYTES = 8;
  localparam int IDW      = ID_BYTES * 8;
  localparam int IXW      = $clog2(IDW);
  localparam int DMAX1    = (SKIP_DLY > VERIFY_DLY) ? SKIP_DLY : VERIFY_DLY;
  localparam int DMAX     = (DMAX1 > BIT_DLY) ? DMAX1 : BIT_DLY;
  localparam int DW       = $clog2(DMAX + 1);

  seq_state_e     state_q, state_d;
  logic [IDW-1:0] id_q, id_d, rb_q, rb_d, id_fixed;
  logic [IXW-1:0] idx_q, idx_d;
  logic [7:0]     status_q, status_d;
  logic           done_q, done_d;
  logic           fam_fixed, crc_fixed, all_zero;
  logic           tmr_run, tmr_exp;
  logic [DW-1:0]  tmr_limit;
  logic           id_en, rb_en;
  ow_op_e         op;

  ow_id_fix #(.ID_BYTES(ID_BYTES), .FAMILY_CODE(FAMILY_CODE)) i_fix (
    .id_raw(id_in), .id_fixed(id_fixed), .fam_fixed(fam_fixed),
    .crc_fixed(crc_fixed), .all_zero(all_zero));

  ow_delay_timer #(.W(DW)) i_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_limit),
    .expired(tmr_exp));

  always_comb begin
    state_d   = state_q;
    id_d      = id_q;
    rb_d      = rb_q;
    idx_d     = idx_q;
    status_d  = status_q;
    done_d    = done_q;
    bus_req   = 1'b0;
    op        = OP_RESET;
    bus_wdata = 8'h00;
    tmr_run   = 1'b0;
    tmr_limit = '0;
    case (state_q)
      S_IDLE: if (start) begin
        done_d = 1'b0;
        if (all_zero) begin
          status_d = '0;
          status_d[ST_ERR]  = 1'b1;
          status_d[ST_ZERO] = 1'b1;
          done_d = 1'b1;
        end else begin
          id_d     = id_fixed;
          status_d = '0;
          status_d[ST_FAM_FIX] = fam_fixed;
          status_d[ST_CRC_FIX] = crc_fixed;
          state_d  = S_RST1;
        end
      end
      S_RST1: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          if (!bus_presence) begin
            status_d[ST_ERR] = 1'b1;
            done_d = 1'b1;
            state_d = S_IDLE;
          end else state_d = S_SKIP;
        end
      end
      S_SKIP: begin
        bus_req = 1'b1; op = OP_WBYTE; bus_wdata = CMD_SKIP;
        if (bus_ack) state_d = S_DLY1;
      end
      S_DLY1: begin
        tmr_run = 1'b1; tmr_limit = DW'(SKIP_DLY);
        if (tmr_exp) state_d = S_RST2;
      end
      S_RST2: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          if (!bus_presence) begin
            status_d[ST_ERR] = 1'b1;
            status_d[ST_NP2] = 1'b1;
            done_d = 1'b1;
            state_d = S_IDLE;
          end else state_d = S_WCMD;
        end
      end
      S_WCMD: begin
        bus_req = 1'b1; op = OP_WBYTE; bus_wdata = CMD_WRID;
        if (bus_ack) begin
          idx_d = '0;
          state_d = S_WSLOT;
        end
      end
      S_WSLOT: begin
        bus_req = 1'b1; op = OP_WSLOT; bus_wdata = {7'b0, ~id_q[idx_q]};
        if (bus_ack) state_d = S_WDLY;
      end
      S_WDLY: begin
        tmr_run = 1'b1; tmr_limit = DW'(BIT_DLY);
        if (tmr_exp) begin
          idx_d = idx_q + 1'b1;
          state_d = (idx_q == IXW'(IDW - 1)) ? S_DLY2 : S_WSLOT;
        end
      end
      S_DLY2: begin
        tmr_run = 1'b1; tmr_limit = DW'(VERIFY_DLY);
        if (tmr_exp) state_d = S_RST3;
      end
      S_RST3: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          if (!bus_presence) begin
            status_d[ST_ERR] = 1'b1;
            status_d[ST_NP3] = 1'b1;
            done_d = 1'b1;
            state_d = S_IDLE;
          end else state_d = S_RCMD;
        end
      end
      S_RCMD: begin
        bus_req = 1'b1; op = OP_WBYTE; bus_wdata = CMD_READID;
        if (bus_ack) begin
          idx_d = '0;
          state_d = S_RBYTE;
        end
      end
      S_RBYTE: begin
        bus_req = 1'b1; op = OP_RBYTE;
        if (bus_ack) begin
          rb_d[{idx_q[2:0], 3'b000} +: 8] = bus_rdata;
          idx_d = idx_q + 1'b1;
          if (idx_q[2:0] == 3'd7) state_d = S_FIN;
        end
      end
      S_FIN: begin
        if (rb_q != id_q) begin
          status_d[ST_ERR]    = 1'b1;
          status_d[ST_VERIFY] = 1'b1;
        end
        done_d = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign id_en = (state_q == S_IDLE) && start && !all_zero;
  assign rb_en = (state_q == S_RBYTE) && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      status_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      status_q <= status_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
      rb_q <= '0;
    end else begin
      if (id_en) id_q <= id_d;
      if (rb_en) rb_q <= rb_d;
    end
  end

  assign busy   = (state_q != S_IDLE);
  assign done   = done_q;
  assign status = status_q;
  assign bus_op = op;

  // R1: no bus traffic while idle (covers the rejected all-zero case)
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
  // R10: busy and done exclusive
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R10: result held until the next start
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(status)));
  // R9: a success code has no bits above bit 1
  p_ok_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !status[ST_ERR]) |-> (status[7:2] == 6'd0));
  // R7: second-reset failure always flagged as error
  p_np2_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[ST_NP2]) |-> status[ST_ERR]);
  // R8: third-reset failure always flagged as error
  p_np3_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[ST_NP3]) |-> status[ST_ERR]);
  // R4: request payload held until acknowledged
  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_wdata)));

endmodule

// File: tb/test_ow_key_prog.sv
module test_ow_key_prog;
  localparam int SKIP_D = 5;
  localparam int BIT_D  = 3;
  localparam int VER_D  = 7;

  logic        clk, rst_n, start;
  logic [63:0] id_in;
  logic        busy, done;
  logic [7:0]  status;
  logic        bus_req;
  logic [1:0]  bus_op;
  logic [7:0]  bus_wdata;
  logic        bus_ack, bus_presence;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int fails  = 0;

  logic [1:0]  op_log  [0:127];
  logic [7:0]  dat_log [0:127];
  int          gap_log [0:127];
  int          op_n, rst_seen, slot_n, rd_n, gap, fail_rst;
  bit          corrupt;
  logic [63:0] key;

  ow_key_prog #(.SKIP_DLY(SKIP_D), .BIT_DLY(BIT_D), .VERIFY_DLY(VER_D)) i_ow_key_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .id_in(id_in), .busy(busy),
    .done(done), .status(status), .bus_req(bus_req), .bus_op(bus_op),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_presence(bus_presence),
    .bus_rdata(bus_rdata));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] crc8(input logic [55:0] m);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic mix = c[0] ^ m[i];
      c = c >> 1;
      if (mix) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] good_id(input logic [55:0] body);
    return {crc8(body), body};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // key and bus master model
  initial begin
    bus_ack = 1'b0; bus_presence = 1'b0; bus_rdata = 8'h00; gap = 0;
    @(negedge clk);
    forever begin
      if (rst_n && bus_req) begin
        logic pres;
        logic [7:0] rd;
        pres = 1'b1; rd = 8'h00;
        op_log[op_n] = bus_op; dat_log[op_n] = bus_wdata; gap_log[op_n] = gap;
        op_n++;
        if (bus_op == 2'd0) begin rst_seen++; pres = (rst_seen != fail_rst); end
        if (bus_op == 2'd2) begin key[slot_n] = ~bus_wdata[0]; slot_n++; end
        if (bus_op == 2'd3) begin
          rd = key[rd_n*8 +: 8] ^ ((corrupt && rd_n == 3) ? 8'h10 : 8'h00);
          rd_n++;
        end
        repeat (2) @(negedge clk);
        bus_ack = 1'b1; bus_presence = pres; bus_rdata = rd;
        @(negedge clk);
        bus_ack = 1'b0; gap = 1;
      end else begin
        @(negedge clk);
        gap++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic clear_model(input int fr, input bit cor);
    op_n = 0; rst_seen = 0; slot_n = 0; rd_n = 0; fail_rst = fr; corrupt = cor;
    key = '0;
  endtask

  task automatic pulse_start(input logic [63:0] id);
    @(negedge clk);
    id_in = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    chk(!busy && !done && status == 8'h00 && !bus_req, "R10 reset state",
        {busy, done, bus_req, status}, 0);
  endtask

  task automatic t_zero;
    clear_model(0, 0);
    pulse_start(64'h0);
    chk(done && !busy && status == 8'hA0, "R1 zero rejected", {done, busy, status}, {2'b10, 8'hA0});
    repeat (10) @(negedge clk);
    chk(op_n == 0, "R1 no bus traffic", op_n, 0);
  endtask

  task automatic t_good;
    logic [63:0] id = good_id(56'h3A_5C_91_0F_E2_47_01);
    int bad = 0;
    clear_model(0, 0);
    pulse_start(id);
    wait_done();
    chk(status == 8'h00, "R9 clean success", status, 8'h00);
    chk(op_n == 78, "R4 operation count", op_n, 78);
    for (int i = 0; i < 78; i++) begin
      logic [1:0] eo; logic [7:0] ed; bit cd;
      cd = 1'b1; ed = 8'h00;
      if (i == 0 || i == 2 || i == 68) begin eo = 2'd0; cd = 1'b0; end
      else if (i == 1) begin eo = 2'd1; ed = 8'hCC; end
      else if (i == 3) begin eo = 2'd1; ed = 8'hD5; end
      else if (i == 69) begin eo = 2'd1; ed = 8'h33; end
      else if (i >= 70) begin eo = 2'd3; cd = 1'b0; end
      else begin eo = 2'd2; ed = {7'b0, ~id[i-4]}; end
      if (op_log[i] != eo || (cd && dat_log[i] != ed)) bad++;
    end
    chk(bad == 0, "R4 operation order and slot values", bad, 0);
    chk(key == id, "R4 key contents", key, id);
    chk(gap_log[2] == SKIP_D + 1, "R5 gap before second reset", gap_log[2], SKIP_D + 1);
    chk(gap_log[5] == BIT_D + 1, "R5 gap between slots", gap_log[5], BIT_D + 1);
    chk(gap_log[68] == BIT_D + VER_D + 1, "R5 gap before third reset", gap_log[68], BIT_D + VER_D + 1);
    chk(gap_log[1] == 1 && gap_log[4] == 1, "R5 no-delay gaps", {gap_log[1], gap_log[4]}, {32'd1, 32'd1});
  endtask

  task automatic t_fix;
    logic [55:0] body = 56'hAB_CD_EF_01_23_45_01;
    logic [63:0] fixed = good_id(body);
    // family 0x28, check byte already correct for the repaired identity
    clear_model(0, 0);
    pulse_start({fixed[63:8], 8'h28});
    wait_done();
    chk(status == 8'h02, "R2 family-only repair", status, 8'h02);
    chk(key == fixed, "R2 family written as 0x01", key, fixed);
    clear_model(0, 0);
    pulse_start({~fixed[63:56], fixed[55:0]});
    wait_done();
    chk(status == 8'h01, "R3 crc-only repair", status, 8'h01);
    chk(key == fixed, "R3 crc replaced", key, fixed);
    clear_model(0, 0);
    pulse_start({~fixed[63:56], fixed[55:8], 8'h28});
    wait_done();
    chk(status == 8'h03, "R3 both repaired", status, 8'h03);
  endtask

  task automatic t_presence;
    logic [63:0] id = good_id(56'h11_22_33_44_55_66_01);
    clear_model(1, 0);
    pulse_start({id[63:8], 8'h77});
    wait_done();
    chk(status == 8'h82 && op_n == 1, "R6 first reset no presence", {status, op_n[7:0]}, {8'h82, 8'd1});
    clear_model(2, 0);
    pulse_start(id);
    wait_done();
    chk(status == 8'h84 && op_n == 3, "R7 second reset no presence", {status, op_n[7:0]}, {8'h84, 8'd3});
    clear_model(3, 0);
    pulse_start(id);
    wait_done();
    chk(status == 8'h88 && op_n == 69, "R8 third reset no presence", {status, op_n[7:0]}, {8'h88, 8'd69});
  endtask

  task automatic t_verify;
    clear_model(0, 1);
    pulse_start(good_id(56'h0A_0B_0C_0D_0E_0F_01));
    wait_done();
    chk(status == 8'h90, "R9 read-back mismatch", status, 8'h90);
  endtask

  task automatic t_busy;
    logic [63:0] id1 = good_id(56'h99_88_77_66_55_44_01);
    logic [63:0] id2 = good_id(56'h12_34_56_78_9A_BC_01);
    clear_model(0, 0);
    pulse_start(id1);
    repeat (20) @(negedge clk);
    pulse_start(id2);
    wait_done();
    chk(key == id1 && status == 8'h00, "R10 start ignored while busy", key, id1);
    repeat (6) @(negedge clk);
    chk(done && status == 8'h00 && !busy, "R10 result held", {done, status}, {1'b1, 8'h00});
    clear_model(0, 0);
    pulse_start(id2);
    chk(!done && busy, "R10 new start clears done", {done, busy}, 2'b01);
    wait_done();
    chk(key == id2, "R10 second run programs new id", key, id2);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; id_in = '0;
    clear_model(0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_good();
    t_fix();
    t_presence();
    t_verify();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule